// File: doc/BRIEF.md
# Dual-Channel Priority Interrupt Sorter

This block picks, for each of two interrupt channels, the single most urgent request among a wide vector of interrupt lines. One channel serves the normal interrupt path and the other the fast interrupt path. Each line carries four pieces of state from outside the block: a pending bit, a mask bit, a route bit that selects its channel, and a priority value. A binary reduction tree finds the winner for each channel, and a small controller per channel turns that winner into a request output and a latched source number.

Each channel works as a handshake. When a channel raises its request it disarms itself and freezes the source number. The request then stays high until software sends that channel a re-arm strobe. The strobe drops the request and arms the channel again. If a line is still eligible, the request comes back after the pipeline delay, carrying the new winner. A single global mask input can hold back new requests on both channels.

Top module: `dual_prio_sorter`

## Requirements
- R1: A line competes on a channel only when its pending bit is 1, its mask bit is 0, and its route bit selects that channel (route 1 = fast channel `fiq_o`, route 0 = normal channel `irq_o`).
- R2: Among eligible lines, the one with the numerically smallest priority value wins; priority 0 is the most urgent.
- R3: When several eligible lines share the best priority, the line with the highest line number wins.
- R4: A channel raises its request only when it is armed, at least one line is eligible for it, and `glb_mask_i` was 0 in the deciding cycle; while `glb_mask_i` is 1 no request rises.
- R5: When a request rises, the winner's line number appears on that channel's source output in the same cycle. The source output keeps that value until the channel's next rise, and it reads 0 after reset.
- R6: Once high, a request stays high until its channel's re-arm strobe; changes on the lines do not re-fire it or change its source.
- R7: A re-arm strobe pulled high for one cycle drives that request low at the next clock edge and arms the channel. If a line is still eligible, the request rises again one edge later. A re-arm in the same cycle as a would-be rise takes precedence.
- R8: During and straight after reset both requests are low, both source outputs are 0, and both channels are armed.
- R9: A line made eligible before clock edge k, on an armed and unmasked channel, raises the request at edge k+1: one edge to register the tree result and one to fire.
- R10: The channels are independent: a re-arm on one channel leaves the other channel's request and source unchanged.
- R11: If a channel is re-armed while no line is eligible, its request stays low and the channel stays armed. It fires as soon as a line becomes eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_pend_i | input | LINES | Pending bit per line |
| line_mask_i | input | LINES | Mask bit per line, 1 = masked |
| line_fiq_i | input | LINES | Route bit per line, 1 = fast channel, 0 = normal channel |
| line_prio_i | input | LINES*PRIO_W | Priority per line; line k uses bits [k*PRIO_W +: PRIO_W] |
| glb_mask_i | input | 1 | Global mask, 1 blocks new requests on both channels |
| rearm_irq_i | input | 1 | Re-arm strobe for the normal channel |
| rearm_fiq_i | input | 1 | Re-arm strobe for the fast channel |
| irq_o | output | 1 | Normal channel request |
| fiq_o | output | 1 | Fast channel request |
| irq_src_o | output | ID_W | Latched winning line number, normal channel |
| fiq_src_o | output | ID_W | Latched winning line number, fast channel |

## Verification
The bound checker watches the handshake on every cycle for both channels:
- a request drops after each re-arm strobe and otherwise holds;
- a rise needs an eligible line two samples earlier and an open global mask;
- the source output never moves except on a rise.

Only the bench's scenarios can show which line wins. These cover priority ordering, tie-breaking toward the higher line number, the effect of routing and masking, re-arming with nothing pending, and channel independence. A cycle-level reference model in the bench compares both requests and both sources on every cycle of a long random run.

// File: rtl/dual_prio_sorter_pkg.sv
package dual_prio_sorter_pkg;

  localparam int NUM_CH = 2;

  typedef enum logic {
    CH_IRQ = 1'b0,
    CH_FIQ = 1'b1
  } chan_e;

  // width of a line number for a given line count, never below one bit
  function automatic int idw(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/prio_sorter_tree.sv
// Binary winner-select tree over the eligible lines; root registered.
module prio_sorter_tree #(
  parameter int LINES  = 96,
  parameter int PRIO_W = 6,
  parameter int ID_W   = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LINES-1:0]        elig_i,
  input  logic [LINES*PRIO_W-1:0] prio_i,
  output logic                    win_valid_o,
  output logic [ID_W-1:0]         win_id_o
);

  localparam int LVLS   = (LINES > 1) ? $clog2(LINES) : 0;
  localparam int LEAVES = 1 << LVLS;
  localparam int NODES  = 2 * LEAVES - 1;

  typedef struct packed {
    logic              v;
    logic [PRIO_W-1:0] p;
    logic [ID_W-1:0]   id;
  } node_t;

  node_t nd [NODES];

  // leaves: heap slot LEAVES-1+k holds line k; padding leaves never win
  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < LINES) begin : g_real
      assign nd[LEAVES-1+k] = '{v: elig_i[k], p: prio_i[k*PRIO_W +: PRIO_W], id: ID_W'(k)};
    end else begin : g_pad
      assign nd[LEAVES-1+k] = '{v: 1'b0, p: '0, id: '0};
    end
  end

  // inner nodes: right child covers higher line numbers, so it takes ties
  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_node
    logic take_hi;
    assign take_hi = nd[2*i+2].v && (!nd[2*i+1].v || (nd[2*i+2].p <= nd[2*i+1].p));
    assign nd[i]   = take_hi ? nd[2*i+2] : nd[2*i+1];
  end

  logic            win_v_d, win_v_q;
  logic [ID_W-1:0] win_id_d, win_id_q;
  logic            win_en;

  always_comb begin
    win_en   = 1'b1;
    win_v_d  = nd[0].v;
    win_id_d = nd[0].v ? nd[0].id : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_v_q  <= 1'b0;
      win_id_q <= '0;
    end else if (win_en) begin
      win_v_q  <= win_v_d;
      win_id_q <= win_id_d;
    end
  end

  assign win_valid_o = win_v_q;
  assign win_id_o    = win_id_q;

endmodule

// File: rtl/prio_sorter_chan.sv
// Per-channel agreement handshake: fire once, hold until re-armed.
module prio_sorter_chan #(
  parameter int ID_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            win_valid_i,
  input  logic [ID_W-1:0] win_id_i,
  input  logic            gmask_i,
  input  logic            rearm_i,
  output logic            req_o,
  output logic [ID_W-1:0] src_o
);

  logic            armed_d, armed_q;
  logic            req_d, req_q;
  logic [ID_W-1:0] src_d, src_q;
  logic            fire, state_en;

  always_comb begin
    fire     = armed_q && win_valid_i && !gmask_i && !rearm_i;
    state_en = rearm_i || fire;
    armed_d  = armed_q;
    req_d    = req_q;
    src_d    = src_q;
    if (rearm_i) begin
      armed_d = 1'b1;
      req_d   = 1'b0;
    end else if (fire) begin
      armed_d = 1'b0;
      req_d   = 1'b1;
      src_d   = win_id_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      req_q   <= 1'b0;
      src_q   <= '0;
    end else begin
      if (state_en) begin
        armed_q <= armed_d;
        req_q   <= req_d;
      end
      if (fire) begin
        src_q <= src_d;
      end
    end
  end

  assign req_o = req_q;
  assign src_o = src_q;

endmodule

// File: rtl/dual_prio_sorter.sv
module dual_prio_sorter
  import dual_prio_sorter_pkg::*;
#(
  parameter int LINES  = 96,
  parameter int PRIO_W = 6,
  parameter int ID_W   = dual_prio_sorter_pkg::idw(LINES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LINES-1:0]        line_pend_i,
  input  logic [LINES-1:0]        line_mask_i,
  input  logic [LINES-1:0]        line_fiq_i,
  input  logic [LINES*PRIO_W-1:0] line_prio_i,
  input  logic                    glb_mask_i,
  input  logic                    rearm_irq_i,
  input  logic                    rearm_fiq_i,
  output logic                    irq_o,
  output logic                    fiq_o,
  output logic [ID_W-1:0]         irq_src_o,
  output logic [ID_W-1:0]         fiq_src_o
);

  logic [NUM_CH-1:0] rearm;
  logic [NUM_CH-1:0] req;
  logic [ID_W-1:0]   src [NUM_CH];

  assign rearm[CH_IRQ] = rearm_irq_i;
  assign rearm[CH_FIQ] = rearm_fiq_i;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [LINES-1:0] route_sel;
    logic [LINES-1:0] elig;
    logic             win_v;
    logic [ID_W-1:0]  win_id;

    if (ch == int'(CH_FIQ)) begin : g_fast
      assign route_sel = line_fiq_i;
    end else begin : g_norm
      assign route_sel = ~line_fiq_i;
    end

    assign elig = line_pend_i & ~line_mask_i & route_sel;

    prio_sorter_tree #(
      .LINES (LINES),
      .PRIO_W(PRIO_W),
      .ID_W  (ID_W)
    ) u_tree (
      .clk        (clk),
      .rst_n      (rst_n),
      .elig_i     (elig),
      .prio_i     (line_prio_i),
      .win_valid_o(win_v),
      .win_id_o   (win_id)
    );

    prio_sorter_chan #(
      .ID_W(ID_W)
    ) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .win_valid_i(win_v),
      .win_id_i   (win_id),
      .gmask_i    (glb_mask_i),
      .rearm_i    (rearm[ch]),
      .req_o      (req[ch]),
      .src_o      (src[ch])
    );
  end

  assign irq_o     = req[CH_IRQ];
  assign fiq_o     = req[CH_FIQ];
  assign irq_src_o = src[CH_IRQ];
  assign fiq_src_o = src[CH_FIQ];

endmodule

// File: rtl/dual_prio_sorter_chk.sv
module dual_prio_sorter_chk #(
  parameter int LINES  = 96,
  parameter int PRIO_W = 6,
  parameter int ID_W   = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LINES-1:0]        line_pend_i,
  input logic [LINES-1:0]        line_mask_i,
  input logic [LINES-1:0]        line_fiq_i,
  input logic [LINES*PRIO_W-1:0] line_prio_i,
  input logic                    glb_mask_i,
  input logic                    rearm_irq_i,
  input logic                    rearm_fiq_i,
  input logic                    irq_o,
  input logic                    fiq_o,
  input logic [ID_W-1:0]         irq_src_o,
  input logic [ID_W-1:0]         fiq_src_o
);

  assert_irq_rearm_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_irq_i |=> !irq_o);
  assert_fiq_rearm_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_fiq_i |=> !fiq_o);

  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !rearm_irq_i) |=> irq_o);
  assert_fiq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_o && !rearm_fiq_i) |=> fiq_o);

  assert_irq_gmask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(!glb_mask_i) && $past(!rearm_irq_i)));
  assert_fiq_gmask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> ($past(!glb_mask_i) && $past(!rearm_fiq_i)));

  // R1, R9: a rise needs an eligible line sampled two edges earlier
  assert_irq_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|(line_pend_i & ~line_mask_i & ~line_fiq_i), 2));
  assert_fiq_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> $past(|(line_pend_i & ~line_mask_i & line_fiq_i), 2));

  assert_irq_src_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(irq_o) |-> $stable(irq_src_o));
  assert_fiq_src_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(fiq_o) |-> $stable(fiq_src_o));

endmodule

bind dual_prio_sorter dual_prio_sorter_chk #(
  .LINES (LINES),
  .PRIO_W(PRIO_W),
  .ID_W  (ID_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_pend_i(line_pend_i),
  .line_mask_i(line_mask_i),
  .line_fiq_i (line_fiq_i),
  .line_prio_i(line_prio_i),
  .glb_mask_i (glb_mask_i),
  .rearm_irq_i(rearm_irq_i),
  .rearm_fiq_i(rearm_fiq_i),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o),
  .irq_src_o  (irq_src_o),
  .fiq_src_o  (fiq_src_o)
);

// File: tb/dual_prio_sorter_test.sv
module dual_prio_sorter_test;

  localparam int N  = 96;
  localparam int PW = 6;
  localparam int IW = 7;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    pend, mask, route;
  logic [PW-1:0]   pr [N];
  logic [N*PW-1:0] prio_flat;
  logic            gmask, rearm_i, rearm_f;
  logic            irq_o, fiq_o;
  logic [IW-1:0]   irq_src_o, fiq_src_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model state, index 0 = normal channel, 1 = fast channel
  bit m_arm [2];
  bit m_req [2];
  int m_src [2];
  bit m_wv  [2];
  int m_wid [2];

  always #5 clk = ~clk;

  always_comb begin
    for (int k = 0; k < N; k++) prio_flat[k*PW +: PW] = pr[k];
  end

  dual_prio_sorter #(.LINES(N), .PRIO_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .line_pend_i(pend), .line_mask_i(mask),
    .line_fiq_i(route), .line_prio_i(prio_flat), .glb_mask_i(gmask),
    .rearm_irq_i(rearm_i), .rearm_fiq_i(rearm_f), .irq_o(irq_o),
    .fiq_o(fiq_o), .irq_src_o(irq_src_o), .fiq_src_o(fiq_src_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // winner from R1-style eligibility, R2 priority, R3 ties by ascending scan
  function automatic void model_win(input int ch, output bit v, output int id);
    int best = 0;
    v  = 0;
    id = 0;
    for (int k = 0; k < N; k++) begin
      if (pend[k] && !mask[k] && (int'(route[k]) == ch) && (!v || int'(pr[k]) <= best)) begin
        v    = 1;
        best = int'(pr[k]);
        id   = k;
      end
    end
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_arm[c] = 1; m_req[c] = 0; m_src[c] = 0; m_wv[c] = 0; m_wid[c] = 0;
    end
  endtask

  // one clock: update model at the edge, compare at the following negedge
  task automatic step();
    bit rr [2];
    @(posedge clk);
    rr[0] = rearm_i;
    rr[1] = rearm_f;
    for (int c = 0; c < 2; c++) begin
      if (rr[c]) begin
        m_req[c] = 0; m_arm[c] = 1;
      end else if (m_arm[c] && m_wv[c] && !gmask) begin
        m_req[c] = 1; m_arm[c] = 0; m_src[c] = m_wid[c];
      end
      model_win(c, m_wv[c], m_wid[c]);
    end
    @(negedge clk);
    check("R4/R6 irq request", int'(irq_o), int'(m_req[0]));
    check("R4/R6 fiq request", int'(fiq_o), int'(m_req[1]));
    check("R5 irq source", int'(irq_src_o), m_src[0]);
    check("R5 fiq source", int'(fiq_src_o), m_src[1]);
  endtask

  task automatic pulse_irq();
    rearm_i = 1; step(); rearm_i = 0;
  endtask

  task automatic pulse_fiq();
    rearm_f = 1; step(); rearm_f = 0;
  endtask

  initial begin
    #2_000_000ns;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; pend = '0; mask = '0; route = '0; gmask = 0;
    rearm_i = 0; rearm_f = 0;
    for (int k = 0; k < N; k++) pr[k] = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R8: reset values
    check("R8 irq in reset", int'(irq_o), 0);
    check("R8 fiq in reset", int'(fiq_o), 0);
    check("R8 irq src in reset", int'(irq_src_o), 0);
    check("R8 fiq src in reset", int'(fiq_src_o), 0);
    rst_n = 1;
    step();
    check("R8 irq after reset", int'(irq_o), 0);

    // R2 and R9: line 5 prio 1 beats line 70 prio 3
    pend[5] = 1; pr[5] = 1; pend[70] = 1; pr[70] = 3;
    step();
    check("R9 irq low after one edge", int'(irq_o), 0);
    step();
    check("R9 irq high after two edges", int'(irq_o), 1);
    check("R2 lower value wins", int'(irq_src_o), 5);

    // R6: more urgent line appears, no re-fire and source held
    pr[70] = 0;
    repeat (3) step();
    check("R6 irq held", int'(irq_o), 1);
    check("R6 source held", int'(irq_src_o), 5);

    // R7: re-arm drops then re-raises with new winner
    pulse_irq();
    check("R7 irq dropped", int'(irq_o), 0);
    step();
    check("R7 irq re-raised", int'(irq_o), 1);
    check("R7 new winner", int'(irq_src_o), 70);

    // R3: ties at prio 2 go to the highest line number
    pend = '0; pend[3] = 1; pend[40] = 1; pend[90] = 1;
    pr[3] = 2; pr[40] = 2; pr[90] = 2;
    step();
    pulse_irq();
    step();
    check("R3 tie to highest line", int'(irq_src_o), 90);

    // R1: route 90 to fast channel, mask 40
    route[90] = 1; mask[40] = 1;
    step(); step();
    check("R1 fiq fires", int'(fiq_o), 1);
    check("R1 fiq source", int'(fiq_src_o), 90);
    pulse_irq();
    step();
    check("R1 irq skips routed and masked", int'(irq_src_o), 3);
    // R10: fast channel untouched by normal re-arm
    check("R10 fiq still high", int'(fiq_o), 1);
    check("R10 fiq source kept", int'(fiq_src_o), 90);
    pulse_fiq();
    check("R10 irq unaffected by fiq rearm", int'(irq_o), 1);

    // R4: global mask blocks firing
    gmask = 1;
    step();
    pulse_irq();
    repeat (4) step();
    check("R4 global mask blocks irq", int'(irq_o), 0);
    check("R4 global mask blocks fiq", int'(fiq_o), 0);
    gmask = 0;
    step();
    check("R4 irq after unmask", int'(irq_o), 1);
    check("R4 fiq after unmask", int'(fiq_o), 1);

    // R11: re-arm with nothing eligible
    pend = '0;
    step();
    rearm_i = 1; rearm_f = 1; step(); rearm_i = 0; rearm_f = 0;
    repeat (3) step();
    check("R11 irq stays low", int'(irq_o), 0);
    check("R11 fiq stays low", int'(fiq_o), 0);
    pend[60] = 1; pr[60] = 7; route[60] = 0; mask[60] = 0;
    step(); step();
    check("R11 irq fires later", int'(irq_o), 1);
    check("R11 irq source", int'(irq_src_o), 60);
    check("R11 fiq quiet", int'(fiq_o), 0);

    // random phase, compared against the model every cycle
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if ($urandom_range(0, 3) == 0) pend[$urandom_range(0, N-1)] ^= 1'b1;
      if ($urandom_range(0, 7) == 0) mask[$urandom_range(0, N-1)] ^= 1'b1;
      if ($urandom_range(0, 7) == 0) route[$urandom_range(0, N-1)] ^= 1'b1;
      if ($urandom_range(0, 3) == 0) pr[$urandom_range(0, N-1)] = PW'($urandom_range(0, 3));
      gmask   = ($urandom_range(0, 9) == 0);
      rearm_i = ($urandom_range(0, 6) == 0);
      rearm_f = ($urandom_range(0, 6) == 0);
      step();
    end
    rearm_i = 0; rearm_f = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule